// File: doc/BRIEF.md
# Level-Sensed DMA Request Masking Arbiter

This block sits in front of a multi-channel DMA transfer engine. It watches one active-low, level-sensed request line per channel. Each line passes through a synchronizer, and each cycle the result is taken as that channel's request bit. A fixed-priority arbiter looks only at the request bits that are not masked and grants one channel at a time. It raises that channel's acknowledge, and the acknowledge holds until the engine reports that the operand transfer has finished.

A requester often lets go of its line a few cycles late. If a finished channel were allowed to win the next arbitration on that late request, it would get a transfer it never asked for. To stop this, the block hides the finishing channel's request bit for a short, fixed window after the transfer ends. During that window the other channels can win. The mode of each channel decides when the window is opened. In single-operand mode it opens after every operand. In sequential and non-stop modes it opens only when the engine reports that the byte count has reached zero. While the count is still nonzero, the channel competes again at once.

Top module: `dla_arbiter`

## Requirements
- R1: A synchronous active-high reset drives every acknowledge low and clears every request bit and every mask window.
- R2: A channel requests while its input is held low. With default parameters, an input driven low before clock edge k gives the acknowledge at edge k+2: two synchronizer edges, then one grant edge.
- R3: When several unmasked channels request at once, the lowest-numbered channel is granted. At most one acknowledge is high at any time.
- R4: Once granted, the acknowledge stays high, whatever the other request inputs do, until the clock edge at which the end-of-operand strobe is high. At that edge it drops.
- R5: Each channel has a 2-bit mode field at bits [2c+1:2c] of the mode input: 00 is single operand, 01 is sequential, 10 is non-stop, and 11 behaves as single operand. In single-operand mode, every end-of-operand on the granted channel masks that channel for MASK_CYC = 3 cycles. If the strobe comes at edge E, a request held low is granted again at edge E+4 and not earlier.
- R6: While a channel is masked, the arbitration treats it as not requesting. Another channel that is requesting is granted at edge E+1.
- R7: In sequential mode, an end-of-operand with the byte-count-zero flag low opens no mask. The channel is arbitrated normally at E+1 and wins again if it has the highest priority. With the flag high, the mask is applied as in R5.
- R8: Non-stop mode follows the same rule as R7: the mask opens only on the end-of-operand that comes with byte count zero.
- R9: If the request is released within the window, no grant follows. If it is still held when the window expires, it is taken as a new request.
- R10: An end-of-operand strobe while no acknowledge is high changes nothing. It opens no mask and drops no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_n_i | input | N_CH | Level-sensed request per channel, active low, asynchronous |
| mode_i | input | 2*N_CH | Per-channel transfer mode, 2 bits per channel |
| eop_i | input | 1 | End-of-operand strobe from the transfer engine |
| bcnt_zero_i | input | 1 | Byte count of the active channel is zero, valid with eop_i |
| ack_o | output | N_CH | One-hot acknowledge to the granted channel |

## Verification
The hardest case to reach is a request that arrives late. The mask window has to be shown both hiding a request that is still held and then letting it through as new, and both must be seen on exact cycles. The bench holds a line low across the end-of-operand strobe and samples the acknowledges on every edge from E to E+4. In other runs it releases the line inside the window, or keeps a second channel requesting so that its grant at E+1 is visible. The mode-dependent cases are covered by running the same strobe with the byte-count-zero flag low and then high, in sequential and in non-stop mode.

// File: rtl/dla_pkg.sv
package dla_pkg;
   typedef enum logic [1:0] {
      MODE_SINGLE  = 2'b00,
      MODE_SEQ     = 2'b01,
      MODE_NONSTOP = 2'b10,
      MODE_RSVD    = 2'b11
   } xfer_mode_e;

   function automatic logic mask_on_every_operand(input logic [1:0] m);
      return (m == MODE_SINGLE) || (m == MODE_RSVD);
   endfunction
endpackage

// File: rtl/dla_sync.sv
module dla_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] req_n_i,
   output logic [WIDTH-1:0] req_bit_o
);
   if (STAGES < 1) begin : g_bad_stages
      $error("dla_sync: STAGES must be at least 1");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst) stage_q[s] <= '1;
         else if (s == 0) stage_q[s] <= req_n_i;
         else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
   end

   assign req_bit_o = ~stage_q[STAGES-1];

   assert_sync_reset_R1: assert property (@(posedge clk)
      rst |=> (req_bit_o == '0));
endmodule

// File: rtl/dla_mask_ctr.sv
module dla_mask_ctr #(
   parameter int MASK_CYC = 3,
   localparam int CW = (MASK_CYC < 2) ? 1 : $clog2(MASK_CYC + 1)
) (
   input  logic clk,
   input  logic rst,
   input  logic load_i,
   output logic masked_o
);
   if (MASK_CYC < 0) begin : g_bad_len
      $error("dla_mask_ctr: MASK_CYC must not be negative");
   end

   if (MASK_CYC == 0) begin : g_no_mask
      assign masked_o = 1'b0;
   end else begin : g_counter
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
         if (rst) cnt_q <= '0;
         else if (load_i) cnt_q <= CW'(MASK_CYC);
         else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      end

      assign masked_o = (cnt_q != '0);

      assert_load_window_R5: assert property (@(posedge clk) disable iff (rst)
         load_i |=> (cnt_q == CW'(MASK_CYC)));
      assert_count_down_R9: assert property (@(posedge clk) disable iff (rst)
         (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
      assert_no_overrun_R5: assert property (@(posedge clk) disable iff (rst)
         cnt_q <= CW'(MASK_CYC));
   end
endmodule

// File: rtl/dla_prio_arb.sv
module dla_prio_arb #(
   parameter int N_CH = 4
) (
   input  logic [N_CH-1:0] req_i,
   output logic [N_CH-1:0] grant_o
);
   always_comb begin
      grant_o = '0;
      for (int c = N_CH - 1; c >= 0; c--) begin
         if (req_i[c]) grant_o = N_CH'(1) << c;
      end
   end

   always_comb begin
      assert_onehot_grant_R3: assert ($onehot0(grant_o));
      assert_grant_has_req_R3: assert ((grant_o & ~req_i) == '0);
   end
endmodule

// File: rtl/dla_arbiter.sv
module dla_arbiter #(
   parameter int N_CH        = 4,
   parameter int SYNC_STAGES = 2,
   parameter int MASK_CYC    = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [N_CH-1:0]   req_n_i,
   input  logic [2*N_CH-1:0] mode_i,
   input  logic              eop_i,
   input  logic              bcnt_zero_i,
   output logic [N_CH-1:0]   ack_o
);
   import dla_pkg::*;

   if (N_CH < 1 || N_CH > 32) begin : g_bad_nch
      $error("dla_arbiter: N_CH out of range");
   end

   logic [N_CH-1:0] req_bit;
   logic [N_CH-1:0] masked;
   logic [N_CH-1:0] eff_req;
   logic [N_CH-1:0] grant;
   logic [N_CH-1:0] end_evt;
   logic [N_CH-1:0] ack_q;
   logic            busy;

   dla_sync #(.WIDTH(N_CH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .req_n_i(req_n_i), .req_bit_o(req_bit)
   );

   assign busy = |ack_q;

   for (genvar c = 0; c < N_CH; c++) begin : g_chan
      logic [1:0] m;
      assign m = mode_i[2*c +: 2];
      assign end_evt[c] = eop_i & ack_q[c] & (mask_on_every_operand(m) | bcnt_zero_i);

      dla_mask_ctr #(.MASK_CYC(MASK_CYC)) u_mask (
         .clk(clk), .rst(rst), .load_i(end_evt[c]), .masked_o(masked[c])
      );

      assign eff_req[c] = req_bit[c] & ~masked[c];

      assert_masked_not_granted_R6: assert property (@(posedge clk) disable iff (rst)
         $rose(ack_q[c]) |-> $past(!masked[c] && req_bit[c]));
      assert_partial_no_mask_R7: assert property (@(posedge clk) disable iff (rst)
         (eop_i && ack_q[c] && !bcnt_zero_i && !mask_on_every_operand(m) && !masked[c])
            |=> !masked[c]);
   end

   dla_prio_arb #(.N_CH(N_CH)) u_arb (.req_i(eff_req), .grant_o(grant));

   always_ff @(posedge clk) begin
      if (rst) ack_q <= '0;
      else if (busy) begin
         if (eop_i) ack_q <= '0;
      end else ack_q <= grant;
   end

   assign ack_o = ack_q;

   assert_ack_onehot_R3: assert property (@(posedge clk) disable iff (rst)
      $onehot0(ack_o));
   assert_ack_hold_R4: assert property (@(posedge clk) disable iff (rst)
      (busy && !eop_i) |=> (ack_o == $past(ack_o)));
   assert_ack_drop_R4: assert property (@(posedge clk) disable iff (rst)
      (busy && eop_i) |=> (ack_o == '0));
   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (ack_o == '0));
   assert_idle_eop_R10: assert property (@(posedge clk) disable iff (rst)
      (!busy && eop_i) |=> (masked == $past(masked) >> 0 || (masked & ~$past(masked)) == '0));
endmodule

// File: tb/dla_arbiter_test.sv
module dla_arbiter_test;
   localparam int N = 4;
   logic clk = 0;
   logic rst = 1;
   logic [N-1:0] req_n = '1;
   logic [2*N-1:0] mode = '0;
   logic eop = 0;
   logic bz = 0;
   logic [N-1:0] ack;
   int checks = 0;
   int fails = 0;
   int cyc = 0;

   always #5 clk = ~clk;

   dla_arbiter #(.N_CH(N)) uut (
      .clk(clk), .rst(rst), .req_n_i(req_n), .mode_i(mode),
      .eop_i(eop), .bcnt_zero_i(bz), .ack_o(ack)
   );

   task automatic step(int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic chk(string tag, logic [N-1:0] exp);
      checks++;
      if (ack !== exp) begin
         fails++;
         $display("FAIL %s: ack actual %b expected %b", tag, ack, exp);
      end
   endtask

   task automatic do_reset();
      rst = 1; req_n = '1; eop = 0; bz = 0; mode = '0;
      step(2);
      rst = 0;
   endtask

   task automatic pulse_eop(logic zero);
      eop = 1; bz = zero;
      step(1);
      eop = 0; bz = 0;
   endtask

   task automatic t_reset();
      req_n = 4'b0000;
      step(4);
      rst = 1;
      step(1);
      chk("R1 reset clears ack", 4'b0000);
      do_reset();
      chk("R1 idle after reset", 4'b0000);
   endtask

   task automatic t_latency();
      do_reset();
      req_n[2] = 0;
      step(2);
      chk("R2 no ack before sync", 4'b0000);
      step(1);
      chk("R2 ack at third edge", 4'b0100);
   endtask

   task automatic t_priority();
      do_reset();
      req_n = 4'b0101;
      step(3);
      chk("R3 lower index wins", 4'b0010);
   endtask

   task automatic t_hold();
      do_reset();
      req_n[3] = 0;
      step(3);
      chk("R4 grant ch3", 4'b1000);
      req_n[0] = 0;
      req_n[3] = 1;
      step(5);
      chk("R4 held until eop", 4'b1000);
      pulse_eop(0);
      chk("R4 drop on eop", 4'b0000);
      step(1);
      chk("R4 next grant ch0", 4'b0001);
   endtask

   task automatic t_single_mask();
      do_reset();
      req_n[0] = 0;
      step(3);
      chk("R5 first grant", 4'b0001);
      pulse_eop(0);
      chk("R5 masked E", 4'b0000);
      step(1); chk("R5 masked E+1", 4'b0000);
      step(1); chk("R5 masked E+2", 4'b0000);
      step(1); chk("R5 masked E+3", 4'b0000);
      step(1); chk("R9 held request is new at E+4", 4'b0001);
   endtask

   task automatic t_other_wins();
      do_reset();
      req_n = 4'b1100;
      step(3);
      chk("R6 ch0 first", 4'b0001);
      pulse_eop(0);
      step(1);
      chk("R6 ch1 granted while ch0 masked", 4'b0010);
   endtask

   task automatic t_release();
      do_reset();
      req_n[1] = 0;
      step(3);
      chk("R9 grant ch1", 4'b0010);
      pulse_eop(0);
      req_n[1] = 1;
      step(6);
      chk("R9 released in window no grant", 4'b0000);
   endtask

   task automatic t_partial(logic [1:0] md, string nm);
      do_reset();
      mode[1:0] = md; mode[3:2] = md;
      req_n = 4'b1100;
      step(3);
      chk({nm, " first grant"}, 4'b0001);
      pulse_eop(0);
      step(1);
      chk({nm, " nonzero count regrants ch0"}, 4'b0001);
      pulse_eop(1);
      step(1);
      chk({nm, " zero count masks ch0"}, 4'b0010);
   endtask

   task automatic t_idle_eop();
      do_reset();
      pulse_eop(1);
      req_n[0] = 0;
      step(3);
      chk("R10 idle eop opens no mask", 4'b0001);
      pulse_eop(0);
      pulse_eop(1);
      step(2);
      chk("R10 idle eop during window", 4'b0000);
      step(1);
      chk("R10 window unchanged", 4'b0001);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         fails++;
         $display("FAIL watchdog: cycles actual %0d expected <= 50000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      #1;
      do_reset();
      t_reset();
      t_latency();
      t_priority();
      t_hold();
      t_single_mask();
      t_other_wins();
      t_release();
      t_partial(2'b01, "R7 sequential");
      t_partial(2'b10, "R8 nonstop");
      t_idle_eop();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule